// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a 3-wire link to an 8-bit successive-approximation converter that has no chip select. On a start request it drives the converter's start line high for an autozero interval and then drops it, which begins the conversion. It then keeps the serial clock low for a fixed worst-case conversion wait. After the wait it clocks out eight result bits using SPI mode 0 timing: the clock idles low and the host samples on the rising edge. The most significant bit is already on the data line when the first rising edge arrives. The word is reported with a one-cycle completion strobe.

The host can assert a sleep request at any time. This forces the converter into power-down and stops any cycle in progress. If a cycle was cut short, the sequencer runs a recovery pass once the sleep request is released: it waits out the conversion time again and issues eight dummy clocks. Only then does it accept a new request. Every interval is a parameter counted in system-clock cycles. Each interval is checked at elaboration against the minimum it must meet, for the clock frequency given as a parameter.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `cnv_o`, `sclk_o`, `pwrdn_o`, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R2: An accepted start request raises `cnv_o` on the next cycle. `cnv_o` stays high for exactly `START_HI_CYC` cycles and then falls.
- R3: After `cnv_o` falls, `sclk_o` stays low, and `cnv_o` stays low, for exactly `CONV_WAIT_CYC + HALF_CYC` cycles before the first rising edge of `sclk_o`.
- R4: In a transfer, `sclk_o` makes exactly 8 rising edges. Each high phase lasts `HALF_CYC` cycles, each low phase between two rising edges lasts `HALF_CYC` cycles, and `sclk_o` is low whenever no transfer is running.
- R5: The bit on `sdata_i` at each rising edge of `sclk_o` is captured, first bit into bit 7, and `result_o` is the straight-binary value of the 8 bits.
- R6: `done_o` is high for exactly one cycle per completed transfer, on the cycle after the 8th falling edge, with `result_o` already valid. `result_o` holds its value until the next completion.
- R7: `busy_o` is high from the first cycle of `cnv_o` high until the cycle `done_o` is high. A start request made while `busy_o` is high produces no extra `cnv_o` pulse.
- R8: If `sleep_req` is asserted while a cycle is running, then on the next cycle `pwrdn_o` is 1, `cnv_o` and `sclk_o` are 0, and no `done_o` follows for that cycle.
- R9: When `sleep_req` is released after an interrupted cycle, `pwrdn_o` falls. `sclk_o` then stays low for `CONV_WAIT_CYC + HALF_CYC` cycles and makes exactly 8 rising edges without raising `cnv_o`. `busy_o` stays high until those edges are done, and start requests are ignored until then.
- R10: Asserting `sleep_req` while idle sets `pwrdn_o`. Releasing it returns the block to idle on the next cycle with no dummy clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request one conversion and readout |
| sleep_req | input | 1 | Power-down request; aborts a running cycle |
| sdata_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| pwrdn_o | output | 1 | Power-down control to the converter (1 = down) |
| result_o | output | DATA_W | Last converted word |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Sequencer not idle |

## Verification
The bench drives a converter model that presents the first bit only after its own conversion time and shifts on falling clock edges. The model also counts any clock edge that arrives while it is still converting. A sequencer that clocks too early is therefore caught, as is one that samples on the wrong edge, which would return a word shifted by one bit. The words 00, FF, 01, 80 and A5 expose bit-order and off-by-one errors at both ends of the word. Aborts are applied during the autozero pulse and during the transfer. A design that skipped recovery, or counted the wrong number of dummy clocks, would show the wrong edge count or a wrong wait after release. A design that let a sleeping or busy sequencer accept a request would show an extra start pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_ZERO   = 3'd1,
      SQ_CONV   = 3'd2,
      SQ_READ   = 3'd3,
      SQ_DOWN   = 3'd4,
      SQ_RWAIT  = 3'd5,
      SQ_RFLUSH = 3'd6
   } seq_state_t;

   // cycles needed to cover a span given in nanoseconds at a clock in kHz
   function automatic int ns_to_cyc(input int clk_khz, input int span_ns);
      longint prod;
      prod = longint'(clk_khz) * longint'(span_ns);
      return int'((prod + 64'd999_999) / 64'd1_000_000);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_TMR_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(val_i)));  // R2

endmodule

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
   parameter int HALF_CYC = 25,
   parameter int NBITS    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic last_fall_o
);

   localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam int PW = $clog2(NBITS + 1);
   localparam logic [HW-1:0] HRELOAD = HW'(HALF_CYC - 1);
   localparam logic [PW-1:0] PLAST   = PW'(NBITS);

   logic [HW-1:0] hcnt_q;
   logic [PW-1:0] pcnt_q;
   logic          lvl_q;
   logic          tick;

   assign tick = run_i && (hcnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q <= HRELOAD;
         pcnt_q <= '0;
         lvl_q  <= 1'b0;
      end else if (!run_i) begin
         hcnt_q <= HRELOAD;
         pcnt_q <= '0;
         lvl_q  <= 1'b0;
      end else if (tick) begin
         hcnt_q <= HRELOAD;
         lvl_q  <= ~lvl_q;
         if (!lvl_q) pcnt_q <= pcnt_q + 1'b1;
      end else begin
         hcnt_q <= hcnt_q - 1'b1;
      end
   end

   assign sclk_o      = lvl_q & run_i;
   assign rise_o      = tick & ~lvl_q;
   assign last_fall_o = tick & lvl_q & (pcnt_q == PLAST);

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= PLAST);  // R4
   AST_NO_NINTH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (pcnt_q < PLAST));  // R4
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !sclk_o);  // R4

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   input  logic              fin_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] res_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin_i;
         if (fin_i) res_q <= sh_q;
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !fin_i |=> $stable(res_q));  // R6
   AST_NO_SHIFT_AT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
      fin_i |-> !shift_i);  // R5

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter int CLK_KHZ       = 100_000,
   parameter int DATA_W        = 8,
   parameter int START_HI_CYC  = 100,
   parameter int CONV_WAIT_CYC = 3500,
   parameter int HALF_CYC      = 25,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              sleep_req,
   input  logic              sdata_i,
   output logic              cnv_o,
   output logic              sclk_o,
   output logic              pwrdn_o,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o,
   output logic              busy_o
);

   localparam int MIN_START = ns_to_cyc(CLK_KHZ, 1_000);
   localparam int MIN_CONV  = ns_to_cyc(CLK_KHZ, 35_000);
   localparam int MIN_HALF  = ns_to_cyc(CLK_KHZ, 250);
   localparam int TMR_MAX   = max2(START_HI_CYC, CONV_WAIT_CYC);
   localparam int TMR_W     = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] START_LD = TMR_W'(START_HI_CYC - 1);
   localparam logic [TMR_W-1:0] CONV_LD  = TMR_W'(CONV_WAIT_CYC - 1);

   // elaboration-time parameter checks
   generate
      if (START_HI_CYC < MIN_START) begin : g_bad_start
         $error("START_HI_CYC below 1 us autozero minimum");
      end
      if (CONV_WAIT_CYC < MIN_CONV) begin : g_bad_conv
         $error("CONV_WAIT_CYC below 35 us conversion time");
      end
      if (HALF_CYC < MIN_HALF) begin : g_bad_half
         $error("HALF_CYC gives a serial clock above 2 MHz");
      end
      if (SYNC_STAGES >= HALF_CYC) begin : g_bad_sync
         $error("SYNC_STAGES must be shorter than a clock half period");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   seq_state_t st_q, st_d;
   logic       abort_q;
   logic       tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic       tmr_zero;
   logic       sd_sync;
   logic       run;
   logic       rise;
   logic       last_fall;
   logic       fin;

   adc_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sdata_i),
      .q_o   (sd_sync)
   );

   adc_seq_timer #(.CNT_W(TMR_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   assign run = (st_q == SQ_READ) || (st_q == SQ_RFLUSH);

   adc_seq_sclk #(.HALF_CYC(HALF_CYC), .NBITS(DATA_W)) i_sclk (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .sclk_o      (sclk_o),
      .rise_o      (rise),
      .last_fall_o (last_fall)
   );

   adc_seq_capture #(.DATA_W(DATA_W)) i_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_i  (rise && (st_q == SQ_READ) && !sleep_req),
      .bit_i    (sd_sync),
      .fin_i    (fin),
      .result_o (result_o),
      .done_o   (done_o)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      fin      = 1'b0;
      if (sleep_req) begin
         st_d = SQ_DOWN;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (start_req) begin
               st_d     = SQ_ZERO;
               tmr_load = 1'b1;
               tmr_val  = START_LD;
            end
            SQ_ZERO: if (tmr_zero) begin
               st_d     = SQ_CONV;
               tmr_load = 1'b1;
               tmr_val  = CONV_LD;
            end
            SQ_CONV: if (tmr_zero) st_d = SQ_READ;
            SQ_READ: if (last_fall) begin
               st_d = SQ_IDLE;
               fin  = 1'b1;
            end
            SQ_DOWN: begin
               if (abort_q) begin
                  st_d     = SQ_RWAIT;
                  tmr_load = 1'b1;
                  tmr_val  = CONV_LD;
               end else begin
                  st_d = SQ_IDLE;
               end
            end
            SQ_RWAIT:  if (tmr_zero) st_d = SQ_RFLUSH;
            SQ_RFLUSH: if (last_fall) st_d = SQ_IDLE;
            default:   st_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         abort_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (sleep_req && (st_q != SQ_IDLE) && (st_q != SQ_DOWN))
            abort_q <= 1'b1;
         else if ((st_q == SQ_DOWN) && !sleep_req)
            abort_q <= 1'b0;
      end
   end

   assign cnv_o   = (st_q == SQ_ZERO);
   assign pwrdn_o = (st_q == SQ_DOWN);
   assign busy_o  = (st_q != SQ_IDLE);

   AST_CLK_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_CONV) |-> !sclk_o);  // R3
   AST_START_LOW_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !cnv_o);  // R3
   AST_START_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> ($past(start_req) && !$past(busy_o)));  // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);  // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);  // R7
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_o |-> (!sclk_o && !cnv_o));  // R8
   AST_SLEEP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> pwrdn_o);  // R8
   AST_NO_DONE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_o |=> !done_o);  // R8
   AST_RECOVERY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_RWAIT) |-> (!cnv_o && !sclk_o));  // R9

endmodule

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;

   localparam int START_HI = 100;
   localparam int CONV_W   = 3500;
   localparam int HALF     = 25;
   localparam int MODEL_CONV = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic       sleep_req = 1'b0;
   logic       sdata = 1'b0;
   logic       cnv, sclk, pwrdn, done, busy;
   logic [7:0] result;

   always #5 clk = ~clk;

   adc_seq_top #(
      .CLK_KHZ(100_000), .DATA_W(8), .START_HI_CYC(START_HI),
      .CONV_WAIT_CYC(CONV_W), .HALF_CYC(HALF), .SYNC_STAGES(2)
   ) i_adc_seq_top (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .sleep_req(sleep_req),
      .sdata_i(sdata), .cnv_o(cnv), .sclk_o(sclk), .pwrdn_o(pwrdn),
      .result_o(result), .done_o(done), .busy_o(busy)
   );

   int n_chk = 0;
   int n_bad = 0;

   // monitor and converter model state
   logic [7:0] adc_val = 8'h00;
   logic [7:0] m_val = 8'h00;
   int  m_cnt = 0, m_rem = 0, early = 0;
   logic p_cnv = 0, p_sclk = 0, p_pd = 0, p_done = 0;
   int  hi_run = 0, last_hi = 0, cnv_rises = 0, sclk_rises = 0;
   int  gap_cnt = 0, last_gap = 0, ph_cnt = 0, bad_phase = 0;
   int  done_cnt = 0, done_wide = 0, frame_rises = 0;
   bit  gap_arm = 0;

   always @(negedge clk) begin
      // converter model
      if (pwrdn) begin
         m_cnt = 0; m_rem = 0;
      end else if (p_cnv && !cnv) begin
         m_val = adc_val; m_cnt = MODEL_CONV; m_rem = 8;
      end else if (m_cnt > 0) m_cnt--;
      if (sclk && !p_sclk && m_cnt > 0) early++;
      if (!sclk && p_sclk && m_rem > 0) m_rem--;
      sdata = (m_cnt == 0 && m_rem > 0) ? m_val[m_rem-1] : 1'b0;
      // start pulse width
      if (cnv) hi_run++;
      else if (p_cnv) begin last_hi = hi_run; hi_run = 0; end
      if (cnv && !p_cnv) begin cnv_rises++; frame_rises = 0; end
      // quiet gap after start fall or power-up
      if ((p_cnv && !cnv) || (p_pd && !pwrdn)) begin gap_arm = 1; gap_cnt = 1; end
      else if (gap_arm && !sclk) gap_cnt++;
      // clock phases
      if (sclk != p_sclk) begin
         if (p_sclk && ph_cnt != HALF) bad_phase++;
         if (!p_sclk && frame_rises > 0 && ph_cnt != HALF) bad_phase++;
         ph_cnt = 1;
      end else ph_cnt++;
      if (sclk && !p_sclk) begin
         sclk_rises++; frame_rises++;
         if (gap_arm) begin last_gap = gap_cnt; gap_arm = 0; end
      end
      if (!sclk && frame_rises >= 8) frame_rises = 0;
      if (done) done_cnt++;
      if (done && p_done) done_wide++;
      p_cnv = cnv; p_sclk = sclk; p_pd = pwrdn; p_done = done;
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      start_req = 1'b1; step(); start_req = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin seen = 1; break; end
         step();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      chk(!cnv && !sclk && !pwrdn && !done && !busy, "R1", "outputs in reset",
          {cnv, sclk, pwrdn, done, busy}, 0);
      chk(result == 8'h00, "R1", "result in reset", result, 0);
      rst_n = 1'b1; step();
      chk(!cnv && !sclk && !pwrdn && !busy, "R1", "outputs after reset",
          {cnv, sclk, pwrdn, busy}, 0);
   endtask

   task automatic t_convert(input logic [7:0] v);
      int r0, d0, e0, b0;
      bit seen;
      adc_val = v;
      r0 = sclk_rises; d0 = done_cnt; e0 = early; b0 = bad_phase;
      pulse_start();
      chk(cnv == 1'b1, "R2", "start line after request", cnv, 1);
      chk(busy == 1'b1, "R7", "busy after request", busy, 1);
      wait_done(seen);
      chk(seen, "R6", "done seen", seen, 1);
      chk(result == v, "R5", "result word", result, v);
      chk(last_hi == START_HI, "R2", "start high cycles", last_hi, START_HI);
      chk(last_gap == CONV_W + HALF, "R3", "quiet cycles before first edge",
          last_gap, CONV_W + HALF);
      chk(early == e0, "R3", "edges during conversion", early - e0, 0);
      chk(sclk_rises - r0 == 8, "R4", "rising edges", sclk_rises - r0, 8);
      chk(bad_phase == b0, "R4", "phase length errors", bad_phase - b0, 0);
      chk(!busy, "R7", "busy at done", busy, 0);
      step();
      chk(!done && done_cnt - d0 == 1 && done_wide == 0, "R6", "done width",
          done_cnt - d0, 1);
      chk(!sclk, "R4", "clock idles low", sclk, 0);
   endtask

   task automatic t_busy_ignore();
      int c0;
      bit seen;
      adc_val = 8'h5A;
      c0 = cnv_rises;
      pulse_start();
      repeat (300) step();
      pulse_start();
      repeat (2000) step();
      pulse_start();
      wait_done(seen);
      chk(seen && result == 8'h5A, "R7", "result with ignored requests", result, 8'h5A);
      chk(cnv_rises - c0 == 1, "R7", "start pulses", cnv_rises - c0, 1);
      repeat (200) step();
      chk(result == 8'h5A && !busy, "R6", "result held", result, 8'h5A);
      chk(cnv_rises - c0 == 1, "R7", "no late start", cnv_rises - c0, 1);
   endtask

   task automatic t_abort(input bit in_read);
      int d0, c0, r0;
      bit ok;
      adc_val = 8'hC3;
      d0 = done_cnt; c0 = cnv_rises;
      pulse_start();
      if (in_read) begin
         ok = 0;
         for (int i = 0; i < 6000; i++) begin
            if (frame_rises == 3 && sclk) begin ok = 1; break; end
            step();
         end
         chk(ok, "R8", "reached transfer", ok, 1);
      end else repeat (20) step();
      sleep_req = 1'b1; step();
      chk(pwrdn && !cnv && !sclk, "R8", "quiet on sleep", {pwrdn, cnv, sclk}, 4);
      start_req = 1'b1; repeat (5) step(); start_req = 1'b0;
      repeat (300) step();
      chk(done_cnt == d0, "R8", "no done after abort", done_cnt - d0, 0);
      chk(cnv_rises - c0 == 1, "R8", "no start while down", cnv_rises - c0, 1);
      r0 = sclk_rises;
      sleep_req = 1'b0; step();
      chk(!pwrdn && busy, "R9", "recovery busy", {pwrdn, busy}, 1);
      repeat (100) step();
      pulse_start();
      ok = 0;
      for (int i = 0; i < 6000; i++) begin
         if (!busy) begin ok = 1; break; end
         step();
      end
      chk(ok, "R9", "recovery finished", ok, 1);
      chk(sclk_rises - r0 == 8, "R9", "dummy edges", sclk_rises - r0, 8);
      chk(last_gap == CONV_W + HALF, "R9", "recovery wait", last_gap, CONV_W + HALF);
      chk(cnv_rises - c0 == 1 && done_cnt == d0, "R9", "recovery starts nothing",
          cnv_rises - c0, 1);
   endtask

   task automatic t_idle_sleep();
      int r0;
      r0 = sclk_rises;
      sleep_req = 1'b1; step();
      chk(pwrdn == 1'b1 && !cnv, "R10", "power-down from idle", pwrdn, 1);
      repeat (50) step();
      sleep_req = 1'b0; step();
      chk(!pwrdn && !busy, "R10", "idle right after release", {pwrdn, busy}, 0);
      repeat (4000) step();
      chk(sclk_rises == r0, "R10", "no dummy edges", sclk_rises - r0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_convert(8'hA5);
      t_convert(8'h00);
      t_convert(8'hFF);
      t_convert(8'h01);
      t_convert(8'h80);
      t_busy_ignore();
      t_abort(1'b1);
      t_convert(8'h3C);
      t_abort(1'b0);
      t_convert(8'h96);
      t_idle_sleep();
      t_convert(8'h7E);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule